// File: doc/BRIEF.md
# Differential Pair Stop and Power-Down Gating

This block decides, for every pair of an eight-pair clock fan-out, whether the pair runs, is parked, or floats. It derives the output clock phase from the reference clock, with one output period every two reference cycles. Each output of each pair gets a registered 2-bit drive code. The analog stage decodes that code into current steering.

Stop and power-down requests arrive asynchronously and are active low. Each request passes through a two-flop synchronizer. It is then confirmed only when it shows the same level on two consecutive rising edges of the complement output. Each request parks the pairs in the state chosen by its own drive-mode bit.

Parking and resuming happen only at the point where the true output rises. A parked-high output therefore never shows a runt pulse. Resume after a stop is delayed by a clamped number of output periods and applies to all pairs at once. Resume after power-down waits for the lock flag. Per-pair enables combine a pin, whose polarity is set by a strap sampled during reset, with a register bit.

Top module: `ckg_stop_gate`

## Requirements
- R1: The polarity strap is captured only while reset is high. Strap 0 makes an enable pin active high, and strap 1 makes it active low. Changing the strap after reset has no effect.
- R2: Pair i drives only when its enable pin is active and pair_en[i] is 1. Otherwise both of its codes are 00 (Hi-Z). This gating overrides every other condition.
- R3: Each code is 2 bits: 00 is Hi-Z, 10 is driven high, and 11 is toggling. Pair i occupies bits [2i+1:2i] of true_code and of comp_code. When the block is idle, all codes are 11 and `level` alternates on every clock.
- R4: A stop request that is low for a single clock cycle is ignored, and every pair keeps toggling.
- R5: A confirmed stop parks each enabled pair whose stoppable bit is 1. Pairs whose stoppable bit is 0 keep toggling.
- R6: For a stopped pair, stop mode 0 gives true 10 and complement 00, and stop mode 1 gives both codes 00.
- R7: After a stop release is confirmed, all stopped pairs resume in the same clock cycle. The resume comes RESTART_PER output periods later, with RESTART_PER clamped to the range 2 to 6.
- R8: A confirmed power-down parks every enabled pair regardless of its stoppable bit. Power-down mode 0 gives true 10 and complement 00, and mode 1 gives both codes 00.
- R9: After power-down is released, the pairs stay parked while pll_locked is 0. Once pll_locked is 1, all enabled pairs resume in the same cycle.
- R10: When power-down and stop are both in effect, the power-down mode sets the parked state.
- R11: Parking and resuming take effect only where `level` goes from 0 to 1. On the first parked or resumed sample, `level` is 1, and on the sample before it, `level` was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_pol_strap | input | 1 | Enable-pin polarity strap, captured during reset |
| oe_pin | input | NPAIR | Per-pair enable pins |
| stop_req_n | input | 1 | Asynchronous stop request, active low |
| pd_req_n | input | 1 | Asynchronous power-down request, active low |
| pll_locked | input | 1 | Lock flag |
| stop_park_tri | input | 1 | Stop drive mode (0 park high, 1 float) |
| pd_park_tri | input | 1 | Power-down drive mode (0 park high, 1 float) |
| pair_en | input | NPAIR | Per-pair output enable register |
| pair_stoppable | input | NPAIR | Per-pair stoppable register |
| level | output | 1 | Current level of a toggling true output |
| true_code | output | 2*NPAIR | Drive codes of the true outputs |
| comp_code | output | 2*NPAIR | Drive codes of the complement outputs |

## Verification
An enable or register change shows up in the codes one clock later, because the output stage is registered. A stop or power-down request passes two synchronizer flops and then two complement-edge samples, which takes roughly 4 to 6 clocks. The park then appears one clock after the next rising point of the true output. The scoreboard therefore compares steady-state codes only after a settling wait of at least 20 clocks. Resume latency is measured sample by sample from the release. It is compared against the window implied by RESTART_PER, and the same sample is checked for simultaneous resume and a high `level`.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
  typedef enum logic [1:0] {
    DRV_HIZ  = 2'b00,
    DRV_LOW  = 2'b01,
    DRV_HIGH = 2'b10,
    DRV_TOG  = 2'b11
  } drv_e;
endpackage

// File: rtl/ckg_debounce.sv
module ckg_debounce #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_n,
  input  logic sample,
  output logic req
);
  logic [SYNC-1:0] sh;
  logic            prev, rec_n;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[SYNC-2:0], async_n};
  end

  // level must match on two consecutive sample strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      prev  <= 1'b1;
      rec_n <= 1'b1;
    end else if (sample) begin
      prev <= sh[SYNC-1];
      if (sh[SYNC-1] == prev) rec_n <= prev;
    end
  end

  assign req = ~rec_n;
endmodule

// File: rtl/ckg_hold_ctrl.sv
module ckg_hold_ctrl #(
  parameter int RESTART_PER = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic stop_req,
  input  logic pd_req,
  input  logic lock,
  output logic stop_hold,
  output logic pd_hold
);
  localparam int RP = (RESTART_PER < 2) ? 2 : ((RESTART_PER > 6) ? 6 : RESTART_PER);
  localparam int CW = $clog2(RP + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_hold <= 1'b0;
      pd_hold   <= 1'b0;
      cnt       <= '0;
    end else if (tick) begin
      if (stop_req) begin
        stop_hold <= 1'b1;
        cnt       <= '0;
      end else if (stop_hold) begin
        if (cnt == CW'(RP - 1)) begin
          stop_hold <= 1'b0;
          cnt       <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (pd_req)               pd_hold <= 1'b1;
      else if (pd_hold && lock) pd_hold <= 1'b0;
    end
  end
endmodule

// File: rtl/ckg_pair_sel.sv
module ckg_pair_sel
  import ckg_pkg::*;
(
  input  logic  en,
  input  logic  stoppable,
  input  logic  stop_hold,
  input  logic  pd_hold,
  input  logic  stop_tri,
  input  logic  pd_tri,
  output drv_e  t_code,
  output drv_e  c_code
);
  always_comb begin
    t_code = DRV_TOG;
    c_code = DRV_TOG;
    if (!en) begin
      t_code = DRV_HIZ;
      c_code = DRV_HIZ;
    end else if (pd_hold) begin
      t_code = pd_tri ? DRV_HIZ : DRV_HIGH;
      c_code = DRV_HIZ;
    end else if (stop_hold && stoppable) begin
      t_code = stop_tri ? DRV_HIZ : DRV_HIGH;
      c_code = DRV_HIZ;
    end
  end
endmodule

// File: rtl/ckg_stop_gate.sv
module ckg_stop_gate
  import ckg_pkg::*;
#(
  parameter int NPAIR       = 8,
  parameter int RESTART_PER = 3,
  parameter int SYNC        = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               oe_pol_strap,
  input  logic [NPAIR-1:0]   oe_pin,
  input  logic               stop_req_n,
  input  logic               pd_req_n,
  input  logic               pll_locked,
  input  logic               stop_park_tri,
  input  logic               pd_park_tri,
  input  logic [NPAIR-1:0]   pair_en,
  input  logic [NPAIR-1:0]   pair_stoppable,
  output logic               level,
  output logic [2*NPAIR-1:0] true_code,
  output logic [2*NPAIR-1:0] comp_code
);
  logic             ph, inv_q, stop_req, pd_req, stop_hold, pd_hold;
  logic             tick, cr_edge;
  logic [NPAIR-1:0] en_eff;
  drv_e             t_nx [NPAIR];
  drv_e             c_nx [NPAIR];

  always_ff @(posedge clk) begin
    if (rst) ph <= 1'b0;
    else     ph <= ~ph;
  end

  assign tick    = ~ph;  // true output about to rise
  assign cr_edge = ph;   // complement output about to rise

  always_ff @(posedge clk) begin
    if (rst) inv_q <= oe_pol_strap;
  end

  ckg_debounce #(.SYNC(SYNC)) u_stop_db (
    .clk(clk), .rst(rst), .async_n(stop_req_n), .sample(cr_edge), .req(stop_req));
  ckg_debounce #(.SYNC(SYNC)) u_pd_db (
    .clk(clk), .rst(rst), .async_n(pd_req_n), .sample(cr_edge), .req(pd_req));

  ckg_hold_ctrl #(.RESTART_PER(RESTART_PER)) u_hold (
    .clk(clk), .rst(rst), .tick(tick), .stop_req(stop_req), .pd_req(pd_req),
    .lock(pll_locked), .stop_hold(stop_hold), .pd_hold(pd_hold));

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    assign en_eff[i] = (oe_pin[i] ^ inv_q) & pair_en[i];
    ckg_pair_sel u_sel (
      .en(en_eff[i]), .stoppable(pair_stoppable[i]), .stop_hold(stop_hold),
      .pd_hold(pd_hold), .stop_tri(stop_park_tri), .pd_tri(pd_park_tri),
      .t_code(t_nx[i]), .c_code(c_nx[i]));

    always_ff @(posedge clk) begin
      if (rst) begin
        true_code[2*i+:2] <= DRV_HIZ;
        comp_code[2*i+:2] <= DRV_HIZ;
      end else begin
        true_code[2*i+:2] <= t_nx[i];
        comp_code[2*i+:2] <= c_nx[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) level <= 1'b1;
    else     level <= ph;
  end
endmodule

// File: rtl/ckg_stop_gate_chk.sv
module ckg_stop_gate_chk #(
  parameter int NPAIR = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               ph,
  input logic               stop_req,
  input logic               stop_hold,
  input logic               pd_hold,
  input logic               pll_locked,
  input logic [NPAIR-1:0]   en_eff,
  input logic [NPAIR-1:0]   pair_stoppable,
  input logic               level,
  input logic [2*NPAIR-1:0] true_code,
  input logic [2*NPAIR-1:0] comp_code
);
  logic [NPAIR-1:0] tog_t;
  always_comb
    for (int i = 0; i < NPAIR; i++) tog_t[i] = (true_code[2*i+:2] == 2'b11);

  a_r3_level_alternates: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> level != $past(level));

  a_r11_hold_on_rise: assert property (@(posedge clk) disable iff (rst)
    (stop_hold != $past(stop_hold) || pd_hold != $past(pd_hold)) |-> !$past(ph));

  a_r8_pd_parks_all: assert property (@(posedge clk) disable iff (rst)
    pd_hold |=> tog_t == '0);

  a_r7_release_only_when_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(stop_hold) |-> !$past(stop_req));

  a_r9_pd_release_locked: assert property (@(posedge clk) disable iff (rst)
    $fell(pd_hold) |-> $past(pll_locked));

  for (genvar i = 0; i < NPAIR; i++) begin : g_chk
    a_r2_disabled_hiz: assert property (@(posedge clk) disable iff (rst)
      !en_eff[i] |=> (true_code[2*i+:2] == 2'b00 && comp_code[2*i+:2] == 2'b00));
    a_r5_free_run_toggles: assert property (@(posedge clk) disable iff (rst)
      (en_eff[i] && !pd_hold && !pair_stoppable[i]) |=>
        (true_code[2*i+:2] == 2'b11 && comp_code[2*i+:2] == 2'b11));
  end
endmodule

bind ckg_stop_gate ckg_stop_gate_chk #(.NPAIR(NPAIR)) u_chk (
  .clk(clk), .rst(rst), .ph(ph), .stop_req(stop_req), .stop_hold(stop_hold),
  .pd_hold(pd_hold), .pll_locked(pll_locked), .en_eff(en_eff),
  .pair_stoppable(pair_stoppable), .level(level), .true_code(true_code),
  .comp_code(comp_code));

// File: tb/ckg_stop_gate_bench.sv
module ckg_stop_gate_bench;
  localparam int NP = 8;
  localparam int RP = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          strap = 1'b0;
  logic [NP-1:0] oe_pin = '1;
  logic          stop_n = 1'b1, pd_n = 1'b1, lock = 1'b1;
  logic          stop_tri = 1'b0, pd_tri = 1'b0;
  logic [NP-1:0] pair_en = '1, stoppable = 8'h0F;
  logic          level;
  logic [2*NP-1:0] true_code, comp_code;

  int errs = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ckg_stop_gate #(.NPAIR(NP), .RESTART_PER(RP)) u_ckg_stop_gate (
    .clk(clk), .rst(rst), .oe_pol_strap(strap), .oe_pin(oe_pin),
    .stop_req_n(stop_n), .pd_req_n(pd_n), .pll_locked(lock),
    .stop_park_tri(stop_tri), .pd_park_tri(pd_tri), .pair_en(pair_en),
    .pair_stoppable(stoppable), .level(level), .true_code(true_code),
    .comp_code(comp_code));

  typedef struct {
    string       tag;
    logic [15:0] t;
    logic [15:0] c;
  } exp_t;
  exp_t q[$];
  exp_t cur;

  // monitor: pops one expected item per falling edge and compares
  always @(negedge clk) begin
    if (q.size() > 0) begin
      cur = q.pop_front();
      checks++;
      if (true_code !== cur.t || comp_code !== cur.c) begin
        errs++;
        $display("FAIL %s: true=%h comp=%h expected true=%h comp=%h",
                 cur.tag, true_code, comp_code, cur.t, cur.c);
      end
    end
  end

  task automatic push_exp(input string tag, input logic [15:0] t, input logic [15:0] c);
    @(posedge clk);
    q.push_back('{tag, t, c});
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    strap = s;
    rst = 1'b1;
    wn(3);
    rst = 1'b0;
    wn(4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic prev_lvl;
    int   n;
    bit   ok;

    // R3: reset state, then all toggling with alternating level
    @(negedge clk);
    #1;
    checks++;
    if (true_code !== 16'h0 || comp_code !== 16'h0) begin
      errs++;
      $display("FAIL R3 reset: true=%h comp=%h expected 0", true_code, comp_code);
    end
    do_reset(1'b0);
    push_exp("R3 idle toggling", 16'hFFFF, 16'hFFFF);
    prev_lvl = level;
    ok = 1;
    for (int k = 0; k < 4; k++) begin
      wn(1);
      if (level == prev_lvl) ok = 0;
      prev_lvl = level;
    end
    chk(ok, "R3 level alternates", ok, 1);

    // R2: register bit and pin both gate a pair
    @(negedge clk);
    pair_en[5] = 1'b0;
    oe_pin[6]  = 1'b0;
    wn(3);
    push_exp("R2 pair5 reg off, pair6 pin off", 16'hC3FF, 16'hC3FF);
    pair_en = '1;
    oe_pin  = '1;
    wn(3);

    // R1: strap 1 at reset makes pins active low; later change ignored
    do_reset(1'b1);
    push_exp("R1 strap1 pins high disable", 16'h0000, 16'h0000);
    @(negedge clk);
    oe_pin = '0;
    wn(3);
    push_exp("R1 strap1 pins low enable", 16'hFFFF, 16'hFFFF);
    @(negedge clk);
    strap = 1'b0;
    wn(3);
    push_exp("R1 strap change after reset ignored", 16'hFFFF, 16'hFFFF);
    oe_pin = '1;
    do_reset(1'b0);

    // R4: single-cycle stop glitch
    @(negedge clk);
    stop_n = 1'b0;
    @(negedge clk);
    stop_n = 1'b1;
    ok = 1;
    for (int k = 0; k < 20; k++) begin
      wn(1);
      if (true_code !== 16'hFFFF) ok = 0;
    end
    chk(ok, "R4 glitch ignored", ok, 1);

    // R5 R6 R11: stop with park-high mode
    @(negedge clk);
    stop_n = 1'b0;
    prev_lvl = level;
    ok = 0;
    for (int k = 0; k < 40; k++) begin
      wn(1);
      if (true_code[1:0] != 2'b11) begin
        ok = 1;
        chk(prev_lvl == 1'b0 && level == 1'b1, "R11 park on rising point",
            {prev_lvl, level}, 1);
        break;
      end
      prev_lvl = level;
    end
    chk(ok, "R5 stop took effect", ok, 1);
    wn(10);
    push_exp("R5 R6 stop mode0", 16'hFFAA, 16'hFF00);

    // R7 R11: release timing and simultaneous resume
    @(negedge clk);
    stop_n = 1'b1;
    n = 0;
    ok = 0;
    for (int k = 0; k < 40; k++) begin
      wn(1);
      n++;
      if (true_code[1:0] == 2'b11) begin
        ok = 1;
        break;
      end
    end
    chk(ok && n >= 2*RP + 2 && n <= 2*RP + 8, "R7 resume latency", n, 2*RP + 5);
    chk(true_code == 16'hFFFF && comp_code == 16'hFFFF, "R7 simultaneous resume",
        true_code, 16'hFFFF);
    chk(level == 1'b1, "R11 resume on rising point", level, 1);

    // R6: stop with float mode
    @(negedge clk);
    stop_tri = 1'b1;
    stop_n   = 1'b0;
    wn(20);
    push_exp("R6 stop mode1", 16'hFF00, 16'hFF00);
    stop_n = 1'b1;
    wn(25);
    push_exp("R7 back to toggling", 16'hFFFF, 16'hFFFF);

    // R8: power-down parks all, stoppable ignored
    @(negedge clk);
    pd_n = 1'b0;
    wn(20);
    push_exp("R8 pd mode0", 16'hAAAA, 16'h0000);
    @(negedge clk);
    pair_en[2] = 1'b0;
    wn(3);
    push_exp("R2 gating over pd", 16'hAA8A, 16'h0000);
    pair_en = '1;
    pd_tri  = 1'b1;
    wn(3);
    push_exp("R8 pd mode1", 16'h0000, 16'h0000);

    // R10: pd wins over stop
    @(negedge clk);
    pd_tri   = 1'b0;
    stop_tri = 1'b1;
    stop_n   = 1'b0;
    wn(20);
    push_exp("R10 pd mode over stop mode", 16'hAAAA, 16'h0000);

    // R9: parked until lock
    @(negedge clk);
    stop_n = 1'b1;
    lock   = 1'b0;
    pd_n   = 1'b1;
    wn(30);
    push_exp("R9 parked without lock", 16'hAAAA, 16'h0000);
    @(negedge clk);
    lock = 1'b1;
    ok = 0;
    for (int k = 0; k < 20; k++) begin
      wn(1);
      if (true_code[1:0] == 2'b11) begin
        ok = 1;
        break;
      end
    end
    chk(ok && true_code == 16'hFFFF && comp_code == 16'hFFFF,
        "R9 all resume together on lock", true_code, 16'hFFFF);

    wn(5);
    finish_run();
  end
endmodule